// File: doc/BRIEF.md
# GPIO Register Bank

This block is a parameterised bank of general-purpose I/O lines behind a small register bus. Software sees up to four word-wide registers: a pin-state register, a set register, a clear register and a direction register. The output values and per-pin output enables go to a tri-state pad ring. The pad values come back through a two-stage synchroniser and can be read from the pin-state register.

Build-time parameters choose the variant. The word width is 8, 16, 32 or 64, and the number of pins always equals that width. The output style is one of three: plain (the pin-state register is written directly), set-only (the set register holds the whole output word), or set/clear (atomic write-one-to-set and write-one-to-clear). The direction register is either absent, or has output-high polarity, or has input-high polarity. Pins can be numbered little-endian or big-endian. The set and direction registers can each be made write-only.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output value is 0. When a direction register exists, every pin is an input (output enable 0), so an input-high direction register reads all ones and an output-high one reads all zeros.
- R2: A read is requested by `re_i` together with an address. Address 0 is pin state, 1 is set, 2 is clear and 3 is direction. `rdata_o` presents the value on the clock edge that samples the request and then holds it until the next request.
- R3: Reading address 0 returns the pad inputs through two synchronising flops. A pad change made before clock edge k is absent from a read sampled at edge k+1 and present in a read sampled at edge k+2 or later.
- R4: In the plain output style, a write to address 0 loads every output value at once. Writes to addresses 1 and 2 have no effect on the outputs.
- R5: In the set/clear style, a write to address 1 drives high every pin whose data bit is 1 and leaves pins with 0 bits unchanged. Writes to address 0 are ignored.
- R6: In the set/clear style, a write to address 2 drives low every pin whose data bit is 1 and leaves pins with 0 bits unchanged.
- R7: In the set-only style, a write to address 1 loads the full output word (1 drives high, 0 drives low). Writes to addresses 0 and 2 are ignored.
- R8: With the output-high direction register (address 3), a 1 bit enables that pin's output driver and a 0 bit leaves the pin in high impedance.
- R9: With the input-high direction register, a 1 bit makes the pin an input (driver disabled) and a 0 bit makes it an output.
- R10: Without a direction register, every output enable is permanently 1, writes to address 3 are ignored, and address 3 reads 0.
- R11: In big-endian numbering, pin n corresponds to register bit WIDTH-1-n. In little-endian numbering, pin n corresponds to bit n. The mapping applies to outputs, enables, direction and pin-state reads alike.
- R12: Address 1 reads the stored output word only if the style has a set register and that register is readable; otherwise it reads 0. Address 3 reads the direction word only if the direction register exists and is readable; otherwise it reads 0. Address 2 always reads 0.
- R13: Output values and direction change only on a write, and take effect on the clock edge that samples that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | WIDTH | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | WIDTH | Registered read data |
| gpio_in_i | input | WIDTH | Pad input values, pin order |
| gpio_out_o | output | WIDTH | Pad output values, pin order |
| gpio_oe_o | output | WIDTH | Pad output enables, pin order |

## Verification
Three instances run side by side on one shared bus. They cover: set/clear style with input-high direction and big-endian numbering; set-only style with output-high direction, little-endian numbering and write-only registers; and plain style without a direction register. Because the same write reaches all three, each write tells apart the styles that must act on it from those that must ignore it. Directed single-bit writes separate reversed numbering from straight numbering. Overlapping set and clear masks show that zero bits leave pins untouched. A pad change followed by an immediate read, then by a delayed read, fixes the synchroniser depth. Random words and random pad values applied to pins in both directions then confirm that pin-state reads mix driven values and external values correctly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    REG_PIN = 2'd0,
    REG_SET = 2'd1,
    REG_CLR = 2'd2,
    REG_DIR = 2'd3
  } reg_sel_e;

  localparam int OUT_PLAIN    = 0;
  localparam int OUT_SET_ONLY = 1;
  localparam int OUT_SET_CLR  = 2;

  localparam int DIR_NONE     = 0;
  localparam int DIR_OUT_HI   = 1;
  localparam int DIR_IN_HI    = 2;
endpackage

// File: rtl/gpio_bitmap.sv
module gpio_bitmap #(
  parameter int WIDTH      = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] b_o
);
  // reversal is its own inverse, so one instance serves both directions
  for (genvar n = 0; n < WIDTH; n++) begin : g_bit
    if (BIG_ENDIAN) begin : g_rev
      assign b_o[n] = a_i[WIDTH-1-n];
    end else begin : g_str
      assign b_o[n] = a_i[n];
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  // warm-up counter keeps $past inside the post-reset window
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  p_sync_depth_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int OUT_MODE = OUT_SET_CLR,
  parameter int DIR_MODE = DIR_OUT_HI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] oe_o
);
  localparam logic [WIDTH-1:0] DIR_RST = (DIR_MODE == DIR_IN_HI) ? '1 : '0;

  logic [WIDTH-1:0] out_q, out_d;
  logic [WIDTH-1:0] set_mask, clr_mask;

  assign set_mask = (wr_en_i && sel_i == REG_SET) ? wdata_i : '0;
  assign clr_mask = (wr_en_i && sel_i == REG_CLR) ? wdata_i : '0;

  always_comb begin
    out_d = out_q;
    case (OUT_MODE)
      OUT_PLAIN:    if (wr_en_i && sel_i == REG_PIN) out_d = wdata_i;
      OUT_SET_ONLY: if (wr_en_i && sel_i == REG_SET) out_d = wdata_i;
      default:      out_d = (out_q | set_mask) & ~clr_mask; // clear wins
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  if (DIR_MODE == DIR_NONE) begin : g_no_dir
    assign dir_o = '0;
    assign oe_o  = '1;
  end else begin : g_dir
    logic [WIDTH-1:0] dir_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           dir_q <= DIR_RST;
      else if (wr_en_i && sel_i == REG_DIR)  dir_q <= wdata_i;
    end
    assign dir_o = dir_q;
    if (DIR_MODE == DIR_OUT_HI) begin : g_out_hi
      assign oe_o = dir_q;
    end else begin : g_in_hi
      assign oe_o = ~dir_q;
    end

    p_dir_out_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (DIR_MODE == DIR_OUT_HI && wr_en_i && sel_i == REG_DIR) |=> (oe_o == $past(wdata_i)));
    p_dir_in_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (DIR_MODE == DIR_IN_HI && wr_en_i && sel_i == REG_DIR) |=> (oe_o == ~$past(wdata_i)));
    p_dir_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(oe_o));
  end

  p_set_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_MODE == OUT_SET_CLR && wr_en_i && sel_i == REG_SET)
      |=> ((out_o & $past(wdata_i)) == $past(wdata_i)));
  p_set_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_MODE == OUT_SET_CLR && wr_en_i && sel_i == REG_SET)
      |=> ((out_o & ~$past(wdata_i)) == ($past(out_o) & ~$past(wdata_i))));
  p_clr_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_MODE == OUT_SET_CLR && wr_en_i && sel_i == REG_CLR)
      |=> ((out_o & $past(wdata_i)) == '0));
  p_set_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_MODE == OUT_SET_ONLY && wr_en_i && sel_i == REG_SET) |=> (out_o == $past(wdata_i)));
  p_plain_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_MODE == OUT_PLAIN && wr_en_i && sel_i == REG_PIN) |=> (out_o == $past(wdata_i)));
  p_hold_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(out_o));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH        = 16,
  parameter int OUT_MODE     = OUT_SET_CLR,
  parameter int DIR_MODE     = DIR_IN_HI,
  parameter bit BIG_ENDIAN   = 1'b1,
  parameter bit SET_READABLE = 1'b1,
  parameter bit DIR_READABLE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] gpio_in_i,
  output logic [WIDTH-1:0] gpio_out_o,
  output logic [WIDTH-1:0] gpio_oe_o
);
  localparam bit SET_RD = (OUT_MODE != OUT_PLAIN) && SET_READABLE;
  localparam bit DIR_RD = (DIR_MODE != DIR_NONE) && DIR_READABLE;

  if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
    $error("gpio_bank: WIDTH must be 8, 16, 32 or 64");
  end

  reg_sel_e         sel;
  logic [WIDTH-1:0] out_reg, dir_reg, oe_reg;
  logic [WIDTH-1:0] in_sync_pin, in_reg;
  logic [WIDTH-1:0] rd_val, rdata_q;

  assign sel = reg_sel_e'(addr_i);

  gpio_out_regs #(
    .WIDTH   (WIDTH),
    .OUT_MODE(OUT_MODE),
    .DIR_MODE(DIR_MODE)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(we_i),
    .sel_i  (sel),
    .wdata_i(wdata_i),
    .out_o  (out_reg),
    .dir_o  (dir_reg),
    .oe_o   (oe_reg)
  );

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_in_i),
    .q_o   (in_sync_pin)
  );

  gpio_bitmap #(.WIDTH(WIDTH), .BIG_ENDIAN(BIG_ENDIAN)) u_map_in (
    .a_i(in_sync_pin), .b_o(in_reg)
  );
  gpio_bitmap #(.WIDTH(WIDTH), .BIG_ENDIAN(BIG_ENDIAN)) u_map_out (
    .a_i(out_reg), .b_o(gpio_out_o)
  );
  gpio_bitmap #(.WIDTH(WIDTH), .BIG_ENDIAN(BIG_ENDIAN)) u_map_oe (
    .a_i(oe_reg), .b_o(gpio_oe_o)
  );

  always_comb begin
    case (sel)
      REG_PIN: rd_val = in_reg;
      REG_SET: rd_val = SET_RD ? out_reg : '0;
      REG_DIR: rd_val = DIR_RD ? dir_reg : '0;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  p_clr_reads_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == REG_CLR) |=> (rdata_o == '0));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int NDUT = 3;
  localparam int CW [NDUT] = '{16, 8, 32};
  localparam int CS [NDUT] = '{2, 1, 0};   // output style
  localparam int CD [NDUT] = '{2, 1, 0};   // direction style
  localparam bit CBE[NDUT] = '{1'b1, 1'b0, 1'b0};
  localparam bit CSR[NDUT] = '{1'b1, 1'b0, 1'b1};
  localparam bit CDR[NDUT] = '{1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] ext [NDUT];

  logic [15:0] rd_a, out_a, oe_a, in_a;
  logic [7:0]  rd_b, out_b, oe_b, in_b;
  logic [31:0] rd_c, out_c, oe_c, in_c;

  assign in_a = (out_a & oe_a) | (ext[0][15:0] & ~oe_a);
  assign in_b = (out_b & oe_b) | (ext[1][7:0]  & ~oe_b);
  assign in_c = (out_c & oe_c) | (ext[2][31:0] & ~oe_c);

  gpio_bank #(.WIDTH(16), .OUT_MODE(2), .DIR_MODE(2), .BIG_ENDIAN(1'b1),
              .SET_READABLE(1'b1), .DIR_READABLE(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata[15:0]),
    .re_i(re), .rdata_o(rd_a), .gpio_in_i(in_a), .gpio_out_o(out_a), .gpio_oe_o(oe_a));
  gpio_bank #(.WIDTH(8), .OUT_MODE(1), .DIR_MODE(1), .BIG_ENDIAN(1'b0),
              .SET_READABLE(1'b0), .DIR_READABLE(1'b0)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata[7:0]),
    .re_i(re), .rdata_o(rd_b), .gpio_in_i(in_b), .gpio_out_o(out_b), .gpio_oe_o(oe_b));
  gpio_bank #(.WIDTH(32), .OUT_MODE(0), .DIR_MODE(0), .BIG_ENDIAN(1'b0),
              .SET_READABLE(1'b1), .DIR_READABLE(1'b1)) u_dut_c (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata[31:0]),
    .re_i(re), .rdata_o(rd_c), .gpio_in_i(in_c), .gpio_out_o(out_c), .gpio_oe_o(oe_c));

  logic [63:0] act_out [NDUT], act_oe [NDUT], act_rd [NDUT];
  always_comb begin
    act_out[0] = 64'(out_a); act_oe[0] = 64'(oe_a); act_rd[0] = 64'(rd_a);
    act_out[1] = 64'(out_b); act_oe[1] = 64'(oe_b); act_rd[1] = 64'(rd_b);
    act_out[2] = 64'(out_c); act_oe[2] = 64'(oe_c); act_rd[2] = 64'(rd_c);
  end

  // model state, register order
  logic [63:0] mo [NDUT], md [NDUT];
  int n_chk = 0, n_err = 0;

  function automatic logic [63:0] wmask(int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] mapv(logic [63:0] v, int w, bit be);
    logic [63:0] r = '0;
    for (int n = 0; n < w; n++) r[n] = be ? v[w-1-n] : v[n];
    return r;
  endfunction

  function automatic logic [63:0] oe_reg_model(int i);
    if (CD[i] == 0) return wmask(CW[i]);
    if (CD[i] == 1) return md[i];
    return ~md[i] & wmask(CW[i]);
  endfunction

  function automatic logic [63:0] rd_model(int i, logic [1:0] a);
    logic [63:0] m = wmask(CW[i]);
    logic [63:0] op = mapv(mo[i], CW[i], CBE[i]);
    logic [63:0] ep = mapv(oe_reg_model(i), CW[i], CBE[i]);
    logic [63:0] pin = ((op & ep) | (ext[i] & ~ep)) & m;
    case (a)
      2'd0: return mapv(pin, CW[i], CBE[i]);
      2'd1: return (CS[i] != 0 && CSR[i]) ? mo[i] : '0;
      2'd3: return (CD[i] != 0 && CDR[i]) ? md[i] : '0;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pins(string tag);
    for (int i = 0; i < NDUT; i++) begin
      chk($sformatf("%s out dut%0d", tag, i), act_out[i], mapv(mo[i], CW[i], CBE[i]));
      chk($sformatf("%s oe dut%0d", tag, i), act_oe[i], mapv(oe_reg_model(i), CW[i], CBE[i]));
    end
  endtask

  task automatic wr(logic [1:0] a, logic [63:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    for (int i = 0; i < NDUT; i++) begin
      logic [63:0] m = wmask(CW[i]);
      logic [63:0] dm = d & m;
      case (CS[i])
        0: if (a == 2'd0) mo[i] = dm;
        1: if (a == 2'd1) mo[i] = dm;
        default: begin
          if (a == 2'd1) mo[i] = mo[i] | dm;
          if (a == 2'd2) mo[i] = mo[i] & ~dm;
        end
      endcase
      if (CD[i] != 0 && a == 2'd3) md[i] = dm;
    end
  endtask

  // waits for the synchroniser to settle, then reads
  task automatic rd(logic [1:0] a, string tag);
    repeat (2) @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    for (int i = 0; i < NDUT; i++)
      chk($sformatf("%s rd%0d dut%0d", tag, a, i), act_rd[i], rd_model(i, a));
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] snap [NDUT];
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NDUT; i++) begin
      ext[i] = '0;
      mo[i] = '0;
      md[i] = (CD[i] == 2) ? wmask(CW[i]) : '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_pins("R1");
    rd(2'd3, "R1 dir");

    // R11 bit ordering with a single bit
    wr(2'd1, 64'h1);
    chk("R11 be pin15", 64'(out_a[15]), 64'd1);
    chk("R11 be pin0", 64'(out_a[0]), 64'd0);
    chk("R11 le pin0", 64'(out_b[0]), 64'd1);
    chk("R4 set ignored plain", 64'(out_c), 64'd0);

    // R5 set keeps zero bits; R7 load
    wr(2'd1, 64'h00F0);
    chk_pins("R5 R7");
    // R6 clear; R7 clear ignored
    wr(2'd2, 64'h0011);
    chk_pins("R6 R7");
    // R4 plain load, others ignore
    wr(2'd0, 64'hA5A5_A5A5);
    chk_pins("R4 R5");
    // R9 / R8 / R10 direction
    wr(2'd3, 64'hFF00);
    chk_pins("R9 R8 R10");
    wr(2'd3, 64'h0F);
    chk_pins("R8 R9 R10");
    chk("R9 be oe pin0", 64'(oe_a[0]), 64'd1);
    chk("R8 le oe pin3", 64'(oe_b[3]), 64'd1);

    // R12 readback visibility, R2 mapping of addresses
    for (int a = 0; a < 4; a++) rd(2'(a), "R12 R2");

    // R2 hold: no request, data stays
    for (int i = 0; i < NDUT; i++) snap[i] = act_rd[i];
    repeat (4) @(negedge clk);
    for (int i = 0; i < NDUT; i++) chk($sformatf("R2 hold dut%0d", i), act_rd[i], snap[i]);

    // R3 synchroniser depth: read too early sees the old pad value
    rd(2'd0, "R3 base");
    for (int i = 0; i < NDUT; i++) snap[i] = rd_model(i, 2'd0);
    for (int i = 0; i < NDUT; i++) ext[i] = ~ext[i];
    addr = 2'd0; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    for (int i = 0; i < NDUT; i++) chk($sformatf("R3 early dut%0d", i), act_rd[i], snap[i]);
    rd(2'd0, "R3 late");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      wr(2'($urandom % 4), {$urandom, $urandom});
      chk_pins("R13 R4 R5 R6 R7 R8 R9 R11");
      if (it % 8 == 7) begin
        for (int i = 0; i < NDUT; i++) ext[i] = {$urandom, $urandom};
        for (int a = 0; a < 4; a++) rd(2'(a), "R3 R11 R12");
      end
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule